// File: doc/BRIEF.md
# Adaptive Scan Shift Rate Controller

This block paces the shifting of a scan chain from a fast reference clock. It issues a one-cycle shift-enable strobe every k reference cycles, where k is a divisor between 1 and `RATE_STEPS`. Each scan load starts at the largest divisor, which is the rate that is safe when nothing is known about chain activity.

While the chain shifts, the block samples the bit entering the chain and the bit leaving it on every strobe. It counts how often each stream repeats the bit it carried on the previous shift. A repeated bit causes no toggle in the chain. When enough repeats have come in on the input side, the chain holds fewer toggling bits, so the controller shortens the shift period by one step. When enough repeats have gone out on the output side, the quiet stretch has left the chain, so it lengthens the period by one step.

The step threshold is `CHAIN_LEN / RATE_STEPS`. The net effect is that power-limited shifting is kept only where the chain content needs it, and test time goes down.

Top module: `scan_rate_ctrl`

## Requirements
- R1: After reset, `rate_idx` is 0 and `shift_en` stays low until the first `start` pulse.
- R2: The cycle after a `start` pulse, `shift_en` is low, and strobes then arrive every `RATE_STEPS` reference cycles while `rate_idx` is 0.
- R3: `shift_en` is a one-cycle pulse with period `RATE_STEPS - rate_idx` cycles. `rate_idx` 0 is the slowest rate and `RATE_STEPS-1` the fastest. A new `rate_idx` sets the period only from the strobe that ends the period in progress.
- R4: A non-transition is a strobe-sampled bit equal to the previous strobe-sampled bit of the same stream. The first sampled bit after `start` is never a non-transition.
- R5: Once `CHAIN_LEN/RATE_STEPS` net input-side non-transitions have accumulated, `rate_idx` rises by one and that count restarts from zero.
- R6: Once `CHAIN_LEN/RATE_STEPS` net output-side non-transitions have accumulated, `rate_idx` falls by one and that count restarts from zero.
- R7: A strobe on which both streams show a non-transition changes neither count.
- R8: `rate_idx` never exceeds `RATE_STEPS-1`. A step-up at that value is dropped and only restarts the input-side count.
- R9: `rate_idx` never goes below 0. A step-down at 0 is dropped and only restarts the output-side count, with no hidden deficit left behind.
- R10: A `start` pulse sets `rate_idx` to 0 on the next cycle and clears both counts and both previous-bit records.
- R11: `rate_idx` changes only on the cycle after a strobe or a `start`, and by exactly one step when no `start` was involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one cycle is the fastest shift period |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a scan load |
| scan_in_bit | input | 1 | Bit entering the chain, sampled when `shift_en` is high |
| scan_out_bit | input | 1 | Bit leaving the chain, sampled when `shift_en` is high |
| shift_en | output | 1 | Registered one-cycle shift strobe |
| rate_idx | output | clog2(RATE_STEPS) | Current rate step, 0 = slowest |

## Verification
A count that is off by one shows up as a step in `rate_idx` one strobe early or one strobe late. Because the step lands on the cycle right after the deciding strobe, the bench can see it before the next shift. A stale previous-bit record, or a count that survives `start`, shifts the step point in the same way, and the restart test makes this visible. A divisor that is latched at the wrong moment changes the gap between strobes. The bench measures the first gap after a step and the steady gap after it, so a wrong latch point shows up within one shift period.

// File: rtl/scan_rate_pkg.sv
package scan_rate_pkg;

  // Width that holds values 0..v-1, never less than one bit.
  function automatic int width_for(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

  // Identifies the monitored streams in the generate loop.
  typedef enum int {
    STREAM_IN  = 0,
    STREAM_OUT = 1
  } stream_e;

  localparam int NUM_STREAMS = 2;

endpackage

// File: rtl/nt_detect.sv
module nt_detect (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sample,
  input  logic bit_in,
  output logic repeat_hit
);

  logic prev_bit;
  logic prev_valid;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_bit   <= 1'b0;
      prev_valid <= 1'b0;
    end else if (sample) begin
      prev_bit   <= bit_in;
      prev_valid <= 1'b1;
    end
  end

  assign repeat_hit = sample && prev_valid && (bit_in == prev_bit);

endmodule

// File: rtl/step_ctrl.sv
module step_ctrl #(
  parameter int STEPS  = 4,
  parameter int THRESH = 4,
  localparam int IDX_W = scan_rate_pkg::width_for(STEPS),
  localparam int CNT_W = scan_rate_pkg::width_for(THRESH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             up_ev,
  input  logic             dn_ev,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(THRESH - 1);

  logic [CNT_W-1:0] up_cnt;
  logic [CNT_W-1:0] dn_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      up_cnt <= '0;
      dn_cnt <= '0;
      idx    <= '0;
    end else if (up_ev && !dn_ev) begin
      if (up_cnt == CNT_LAST) begin
        up_cnt <= '0;
        if (idx != IDX_TOP) idx <= idx + 1'b1;
      end else begin
        up_cnt <= up_cnt + 1'b1;
      end
    end else if (dn_ev && !up_ev) begin
      if (dn_cnt == CNT_LAST) begin
        dn_cnt <= '0;
        if (idx != '0) idx <= idx - 1'b1;
      end else begin
        dn_cnt <= dn_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen #(
  parameter int STEPS  = 4,
  localparam int IDX_W = scan_rate_pkg::width_for(STEPS),
  localparam int DIV_W = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] idx,
  output logic             strobe
);

  localparam logic [DIV_W-1:0] DIV_SLOW = DIV_W'(STEPS);

  logic             running;
  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] period;
  logic [DIV_W-1:0] next_period;

  assign next_period = DIV_SLOW - DIV_W'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      phase   <= '0;
      period  <= DIV_SLOW;
      strobe  <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      phase   <= '0;
      period  <= DIV_SLOW;
      strobe  <= 1'b0;
    end else if (running) begin
      if (phase == period - 1'b1) begin
        strobe <= 1'b1;
        phase  <= '0;
        period <= next_period;
      end else begin
        strobe <= 1'b0;
        phase  <= phase + 1'b1;
      end
    end else begin
      strobe <= 1'b0;
    end
  end

endmodule

// File: rtl/scan_rate_ctrl.sv
module scan_rate_ctrl #(
  parameter int RATE_STEPS = 4,
  parameter int CHAIN_LEN  = 16,
  localparam int IDX_W     = scan_rate_pkg::width_for(RATE_STEPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             scan_in_bit,
  input  logic             scan_out_bit,
  output logic             shift_en,
  output logic [IDX_W-1:0] rate_idx
);

  import scan_rate_pkg::*;

  localparam int STEP_THRESH = (CHAIN_LEN / RATE_STEPS < 1) ? 1 : CHAIN_LEN / RATE_STEPS;

  logic [NUM_STREAMS-1:0] stream_bits;
  logic [NUM_STREAMS-1:0] stream_rep;

  assign stream_bits[STREAM_IN]  = scan_in_bit;
  assign stream_bits[STREAM_OUT] = scan_out_bit;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    nt_detect u_det (
      .clk        (clk),
      .rst        (rst),
      .clr        (start),
      .sample     (shift_en),
      .bit_in     (stream_bits[s]),
      .repeat_hit (stream_rep[s])
    );
  end

  step_ctrl #(
    .STEPS  (RATE_STEPS),
    .THRESH (STEP_THRESH)
  ) u_step (
    .clk   (clk),
    .rst   (rst),
    .clr   (start),
    .up_ev (stream_rep[STREAM_IN]),
    .dn_ev (stream_rep[STREAM_OUT]),
    .idx   (rate_idx)
  );

  strobe_gen #(
    .STEPS (RATE_STEPS)
  ) u_strobe (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .idx    (rate_idx),
    .strobe (shift_en)
  );

endmodule

// File: rtl/scan_rate_chk.sv
module scan_rate_chk #(
  parameter int RATE_STEPS = 4,
  localparam int IDX_W     = scan_rate_pkg::width_for(RATE_STEPS)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             shift_en,
  input logic [IDX_W-1:0] rate_idx
);

  logic seen_start;

  always_ff @(posedge clk) begin
    if (rst) seen_start <= 1'b0;
    else if (start) seen_start <= 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !seen_start |-> !shift_en); // R1

  AST_START_QUIET: assert property (@(posedge clk) disable iff (rst)
    start |=> !shift_en); // R2

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(rate_idx) <= RATE_STEPS - 1); // R8

  AST_START_SLOWEST: assert property (@(posedge clk) disable iff (rst)
    start |=> (rate_idx == '0)); // R10

  AST_IDX_ON_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (rate_idx != $past(rate_idx)) |-> ($past(shift_en) || $past(start))); // R11

  AST_IDX_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(start) && (rate_idx != $past(rate_idx))) |->
      ((int'(rate_idx) - int'($past(rate_idx)) == 1) ||
       (int'(rate_idx) - int'($past(rate_idx)) == -1))); // R11

endmodule

bind scan_rate_ctrl scan_rate_chk #(.RATE_STEPS(RATE_STEPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .shift_en (shift_en),
  .rate_idx (rate_idx)
);

// File: tb/scan_rate_ctrl_bench.sv
module scan_rate_ctrl_bench;

  localparam int STEPS = 4;
  localparam int CLEN  = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       scan_in_bit = 1'b0;
  logic       scan_out_bit = 1'b0;
  logic       shift_en;
  logic [1:0] rate_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scan_rate_ctrl #(.RATE_STEPS(STEPS), .CHAIN_LEN(CLEN)) u_scan_rate_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .scan_in_bit  (scan_in_bit),
    .scan_out_bit (scan_out_bit),
    .shift_en     (shift_en),
    .rate_idx     (rate_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Present one bit pair and let the next strobe sample it.
  task automatic shift(input logic bi, input logic bo);
    scan_in_bit  = bi;
    scan_out_bit = bo;
    @(negedge clk);
    while (!shift_en) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic wait_strobe(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!shift_en && n < 50);
  endtask

  task automatic t_reset();
    int hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (shift_en) hits++;
    end
    chk("R1 no strobe before start", hits, 0);
    chk("R1 reset rate_idx", rate_idx, 0);
  endtask

  task automatic t_slow();
    int n;
    pulse_start();
    chk("R2 strobe low after start", shift_en, 0);
    chk("R2 idx after start", rate_idx, 0);
    wait_strobe(n);
    wait_strobe(n);
    chk("R2 slowest period", n, STEPS);
  endtask

  task automatic t_up_down();
    int n;
    pulse_start();
    shift(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) shift(1'b0, (i % 2 == 0));
    chk("R4 R5 idx after three repeats", rate_idx, 0);
    shift(1'b0, 1'b0);
    chk("R5 step up after threshold", rate_idx, 1);
    wait_strobe(n);
    chk("R3 old period finishes first", n, 4);
    wait_strobe(n);
    chk("R3 new period", n, 3);
    for (int i = 0; i < 3; i++) shift((i % 2 == 0), 1'b0);
    chk("R6 idx before down threshold", rate_idx, 1);
    shift(1'b0, 1'b0);
    chk("R6 step down after threshold", rate_idx, 0);
  endtask

  task automatic t_cancel();
    pulse_start();
    shift(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) shift(1'b1, 1'b1);
    chk("R7 paired repeats cancel", rate_idx, 0);
    for (int i = 0; i < 3; i++) shift(1'b1, (i % 2 == 1));
    chk("R7 counts untouched by cancels", rate_idx, 0);
    shift(1'b1, 1'b1);
    chk("R7 step after four net repeats", rate_idx, 1);
  endtask

  task automatic t_sat_high();
    int n;
    pulse_start();
    shift(1'b0, 1'b0);
    for (int i = 0; i < 12; i++) shift(1'b0, (i % 2 == 0));
    chk("R8 reached fastest", rate_idx, STEPS - 1);
    wait_strobe(n);
    wait_strobe(n);
    chk("R3 fastest period", n, 1);
    for (int i = 0; i < 4; i++) shift(1'b0, (i % 2 == 0));
    chk("R8 saturates at fastest", rate_idx, STEPS - 1);
    pulse_start();
    chk("R10 start forces slowest", rate_idx, 0);
    wait_strobe(n);
    wait_strobe(n);
    chk("R10 slowest period after start", n, STEPS);
  endtask

  task automatic t_sat_low();
    pulse_start();
    shift(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) shift((i % 2 == 0), 1'b0);
    chk("R9 saturates at slowest", rate_idx, 0);
    for (int i = 0; i < 3; i++) shift(1'b0, (i % 2 == 0));
    chk("R9 no deficit before step", rate_idx, 0);
    shift(1'b0, 1'b0);
    chk("R9 up step unaffected", rate_idx, 1);
  endtask

  task automatic t_restart();
    pulse_start();
    shift(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) shift(1'b1, (i % 2 == 1));
    chk("R10 partial count", rate_idx, 0);
    pulse_start();
    shift(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) shift(1'b1, (i % 2 == 0));
    chk("R10 R4 counts and history cleared", rate_idx, 0);
    shift(1'b1, 1'b0);
    chk("R10 step after fresh threshold", rate_idx, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_slow();
    t_up_down();
    t_cancel();
    t_sat_high();
    t_sat_low();
    t_restart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule